// File: doc/BRIEF.md
# Iterative Base-2 Logarithm Unit

This block turns an unsigned integer magnitude into a fixed-point base-2 logarithm. The integer part of the result is the position of the most significant set bit. A prefix-OR mask finds that position, and a popcount of the mask turns it into a binary index. The fractional part comes from a 32-entry table. The table is addressed by the five bits that sit just below the leading one, after the operand has been normalised.

Normalisation is done by a serial right shifter that moves one bit per clock. The run time therefore grows with the size of the operand: an operand whose leading one is at bit `e` needs `e` shift cycles plus one cycle for the table lookup. A caller pulses `start_i` with an operand while the unit is idle, then waits for the one-cycle `done_o` pulse. The result, together with a flag that marks a zero operand, stays on the outputs until the next result is produced.

Top module: `log2_iter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy_o`, `done_o`, `zero_o` and `res_o` are all zero.
- R2: A `start_i` pulse that arrives while `busy_o` is low is accepted on that clock edge, and `busy_o` is high in the following cycle.
- R3: For a non-zero operand, `res_o[RES_W-1:LUT_W]` (the integer field) equals the bit index of the most significant set bit of the operand.
- R4: For a non-zero operand, `res_o[LUT_W-1:0]` (the fraction field) equals floor(2^LUT_W * log2(1 + f/32)). Here `f` is the 5-bit value of the operand bits directly below the leading one, with zero fill when fewer than five such bits exist.
- R5: Let `e` be the leading-one index. `done_o` is high in the cycle that follows the (e+1)-th rising edge after the accepting edge, so normalisation costs one cycle per bit of shift.
- R6: A zero operand is finished after one cycle with no shifting: `res_o` is zero and `zero_o` is 1. A non-zero operand gives `zero_o` = 0.
- R7: `done_o` is a single-cycle pulse. `res_o` and `zero_o` keep their values from one `done_o` pulse to the next.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. It produces no extra `done_o` and does not change the result of the operation in progress.
- R9: `busy_o` stays high from the accepting edge until the result is produced, and it is low in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operand valid; taken only while idle |
| data_i | input | IN_W | Unsigned operand |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |
| res_o | output | EXP_W+LUT_W | Integer leading-one index concatenated with fractional log of the mantissa |
| zero_o | output | 1 | Result belongs to a zero operand |

## Verification
Some properties are checked on every cycle: that `done_o` lasts one cycle, that it never overlaps `busy_o`, that `busy_o` rises only after a start, that the result holds between strobes, and that a zero flag comes with a zero result. The bench scenarios are needed for the rest. They show that the integer and fractional fields match an independent real-valued logarithm. They show that the latency follows the leading-one position, from bit 0 up to the top bit. They also show that starts issued mid-run leave no trace.

// File: rtl/log2_iter_pkg.sv
package log2_iter_pkg;

  typedef enum logic {ST_IDLE, ST_NORM} state_e;

  // floor(2^out_w * log2(1 + idx/2^idx_w)) by repeated squaring, Q2.30
  function automatic int unsigned log2_frac(int unsigned idx, int unsigned idx_w,
                                            int unsigned out_w);
    longint unsigned y;
    int unsigned     r;
    y = (64'd1 << 30) + (64'(idx) << (30 - idx_w));
    r = 0;
    for (int unsigned b = 0; b < out_w; b++) begin
      y = (y * y) >> 30;
      r = r << 1;
      if (y >= (64'd1 << 31)) begin
        r = r | 32'd1;
        y = y >> 1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/log2_lead_therm.sv
module log2_lead_therm #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned EXP_W = $clog2(IN_W)
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [EXP_W-1:0] pos_o,
  output logic             zero_o
);
  localparam int unsigned CNT_W = $clog2(IN_W + 1);

  logic [IN_W-1:0]  therm;
  logic [CNT_W-1:0] ones;

  // therm[g] set when any bit at or above g is set
  for (genvar g = 0; g < IN_W; g++) begin : g_therm
    assign therm[g] = |val_i[IN_W-1:g];
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < IN_W; i++) begin
      ones = ones + CNT_W'(therm[i]);
    end
  end

  assign zero_o = ~therm[0];
  assign pos_o  = zero_o ? '0 : EXP_W'(ones - CNT_W'(1));

endmodule

// File: rtl/log2_ser_shift.sv
module log2_ser_shift #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned EXP_W = $clog2(IN_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IN_W-1:0]  val_i,
  input  logic [EXP_W-1:0] amt_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             idle_o
);
  localparam int unsigned SH_W = IN_W + IDX_W;

  logic [SH_W-1:0]  sh_q;
  logic [EXP_W-1:0] cnt_q;

  // one position per clock; leading one ends at bit IDX_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= {val_i, {IDX_W{1'b0}}};
      cnt_q <= amt_i;
    end else if (cnt_q != '0) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q - EXP_W'(1);
    end
  end

  assign idx_o  = sh_q[IDX_W-1:0];
  assign idle_o = (cnt_q == '0);

endmodule

// File: rtl/log2_mant_rom.sv
module log2_mant_rom
  import log2_iter_pkg::*;
#(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned OUT_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int unsigned DEPTH = 2 ** IDX_W;

  logic [OUT_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam int unsigned VAL = log2_frac(g, IDX_W, OUT_W);
    assign tbl[g] = OUT_W'(VAL);
  end

  assign val_o = tbl[idx_i];

endmodule

// File: rtl/log2_iter.sv
module log2_iter
  import log2_iter_pkg::*;
#(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned LUT_W = 8,
  localparam int unsigned EXP_W = $clog2(IN_W),
  localparam int unsigned RES_W = EXP_W + LUT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IN_W-1:0]  data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] res_o,
  output logic             zero_o
);

  state_e           state_q;
  logic             accept;
  logic [EXP_W-1:0] lead_pos;
  logic             lead_zero;
  logic [EXP_W-1:0] exp_q;
  logic             zin_q;
  logic [IDX_W-1:0] mant_idx;
  logic             sh_idle;
  logic [LUT_W-1:0] mant_log;
  logic             done_q;
  logic [RES_W-1:0] res_q;
  logic             zero_q;

  assign accept = (state_q == ST_IDLE) && start_i;

  log2_lead_therm #(.IN_W(IN_W), .EXP_W(EXP_W)) u_lead (
    .val_i  (data_i),
    .pos_o  (lead_pos),
    .zero_o (lead_zero)
  );

  log2_ser_shift #(.IN_W(IN_W), .IDX_W(IDX_W), .EXP_W(EXP_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .val_i  (data_i),
    .amt_i  (lead_pos),
    .idx_o  (mant_idx),
    .idle_o (sh_idle)
  );

  log2_mant_rom #(.IDX_W(IDX_W), .OUT_W(LUT_W)) u_rom (
    .idx_i (mant_idx),
    .val_o (mant_log)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      exp_q   <= '0;
      zin_q   <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
      zero_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            exp_q   <= lead_pos;
            zin_q   <= lead_zero;
            state_q <= ST_NORM;
          end
        end
        ST_NORM: begin
          if (sh_idle) begin
            res_q   <= zin_q ? '0 : {exp_q, mant_log};
            zero_q  <= zin_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_NORM);
  assign done_o = done_q;
  assign res_o  = res_q;
  assign zero_o = zero_q;

endmodule

// File: rtl/log2_iter_chk.sv
module log2_iter_chk #(
  parameter int unsigned RES_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] res_o,
  input logic             zero_o
);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(res_o) && $stable(zero_o)));

  // R9
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R2
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R6
  zero_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && zero_o) |-> (res_o == '0));

endmodule

bind log2_iter log2_iter_chk #(.RES_W(RES_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .res_o   (res_o),
  .zero_o  (zero_o)
);

// File: tb/tb_log2_iter.sv
`timescale 1ns/1ps
module tb_log2_iter;
  localparam int IN_W  = 16;
  localparam int LUT_W = 8;
  localparam int EXP_W = 4;
  localparam int RES_W = EXP_W + LUT_W;

  typedef struct {
    logic [RES_W-1:0] res;
    logic             zf;
    int               due;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [IN_W-1:0]  data_i = '0;
  logic             busy_o, done_o, zero_o;
  logic [RES_W-1:0] res_o;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  logic  prev_done = 1'b0;
  logic [RES_W-1:0] last_res = '0;
  logic  last_zero = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  log2_iter dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .res_o(res_o), .zero_o(zero_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int lead(input logic [IN_W-1:0] d);
    int e = 0;
    for (int i = 0; i < IN_W; i++) if (d[i]) e = i;
    return e;
  endfunction

  function automatic logic [RES_W-1:0] model(input logic [IN_W-1:0] d);
    int  e, f, fr;
    real v;
    if (d == 0) return '0;
    e  = lead(d);
    f  = ((int'(d) * 32) >> e) & 31;
    v  = $ln(1.0 + real'(f) / 32.0) / $ln(2.0) * 256.0;
    fr = int'($floor(v));
    return RES_W'((e << LUT_W) | fr);
  endfunction

  task automatic drive(input logic [IN_W-1:0] d);
    item_t it;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    start_i = 1'b1;
    data_i  = d;
    it.res  = model(d);
    it.zf   = (d == 0);
    it.due  = cyc + ((d == 0) ? 0 : lead(d)) + 2;
    q.push_back(it);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R2 busy after accept", longint'(busy_o), 1);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(res_o[RES_W-1:LUT_W] == it.res[RES_W-1:LUT_W], "R3 exponent field",
              longint'(res_o[RES_W-1:LUT_W]), longint'(it.res[RES_W-1:LUT_W]));
          chk(res_o[LUT_W-1:0] == it.res[LUT_W-1:0], "R4 fraction field",
              longint'(res_o[LUT_W-1:0]), longint'(it.res[LUT_W-1:0]));
          chk(zero_o == it.zf, "R6 zero flag", longint'(zero_o), longint'(it.zf));
          chk(cyc == it.due, "R5 latency", longint'(cyc), longint'(it.due));
        end
        chk(!busy_o, "R9 busy low with done", longint'(busy_o), 0);
        chk(!prev_done, "R7 done one cycle", longint'(prev_done), 0);
        last_res  = res_o;
        last_zero = zero_o;
      end else if (res_o !== last_res || zero_o !== last_zero) begin
        chk(1'b0, "R7 result hold", longint'(res_o), longint'(last_res));
      end
      prev_done = done_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, zero_o} == 3'b000 && res_o == '0, "R1 reset outputs",
        longint'({busy_o, done_o, zero_o, res_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, zero_o} == 3'b000 && res_o == '0, "R1 after release",
        longint'({busy_o, done_o, zero_o, res_o}), 0);

    // R6 zero operand, then boundaries for R3/R4/R5
    drive(16'h0000);
    drive(16'h0001);
    drive(16'h0002);
    drive(16'h0003);
    drive(16'h0021);
    drive(16'h00FF);
    drive(16'h8000);
    drive(16'hFFFF);
    drive(16'h7FFF);
    drive(16'h1234);
    drive(16'h0000);
    for (int i = 1; i <= 20; i++) drive(IN_W'(i * 40503 + 17));
    // every fraction index with leading one at bit 5 (R4)
    for (int f = 0; f < 32; f++) drive(IN_W'(32 + f));

    // R8: starts while busy are dropped
    drive(16'h4000);
    @(negedge clk);
    start_i = 1'b1;
    data_i  = 16'h0001;
    @(negedge clk);
    data_i  = 16'h0000;
    @(negedge clk);
    start_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(!busy_o && q.size() == 0, "R8 no extra run", longint'(busy_o), 0);
    chk(res_o == model(16'h4000), "R8 result kept", longint'(res_o), longint'(model(16'h4000)));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule